// File: doc/BRIEF.md
# Dual-channel PWM converter drive controller

This block drives the power switches of two switching converters, one PWM output for each. Each channel stores two programmed settings. A setting is a clock divider code and a duty value in sixteenths of a period. An external select pin for each channel picks which of the two settings drives the output, so board logic can move a converter between two operating points without any register traffic.

The output polarity of each channel comes from a strap input. The block samples the straps while reset is held and keeps that value until the next reset. This lets the same block drive converters that make positive or negative rails.

A feedback input for each channel, driven by an external comparator, suppresses drive while the regulated output is above target. Settings are loaded through a plain write strobe, with an address and a data word.

Top module: `pwm_drive_ctrl`

## Requirements
- R1: While rst_n is low, each channel captures its pol_strap bit as its polarity. After reset, changes on pol_strap have no effect. A polarity of 1 makes the output's inactive level high and its active level low.
- R2: A divider code c (0 to 7) produces one PWM tick every 2^(c+1) clock cycles. One PWM period is 16 ticks, so the period is 16*2^(c+1) clock cycles.
- R3: A duty value d (0 to 15) holds the output at its active level for the first d ticks of the period and at its inactive level for the remaining ticks. d = 0 keeps the output inactive for the whole period.
- R4: Each sel_pin bit passes through a two-flop synchronizer. When the synchronized value is 0, set 0 drives the channel. When it is 1, set 1 drives the channel.
- R5: The divider code, the duty value and the selected set are loaded only at a period boundary. A register write or a select change made in the middle of a period leaves the current period unchanged.
- R6: The fb bit is sampled at each period boundary. If it is 1 there, the whole following period stays at the inactive level. Changes of fb inside a period have no effect on that period.
- R7: The two channels have independent counters, settings, selects and feedback. Activity on one channel never changes the other.
- R8: On a clock edge with wr_en high, wr_data[6:4] (divider code) and wr_data[3:0] (duty) are stored. wr_addr[1] picks the channel and wr_addr[0] picks the set. Reset clears all four settings to 0, and the first period after reset uses divider 0 and duty 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; straps are sampled while it is low |
| pol_strap | input | 2 | Polarity straps, one per channel |
| sel_pin | input | 2 | Asynchronous setting select, one per channel |
| fb | input | 2 | Feedback, 1 = output above target, one per channel |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | {channel, set} of the write |
| wr_data | input | 7 | {divider code[2:0], duty[3:0]} |
| pwm_out | output | 2 | PWM drive, one per channel |

## Verification
The bench aims at the divider-7 period of 4096 cycles. A design that overflows its prescaler would cut that period short. It checks duty 0 and duty 15: an off-by-one compare would give a stray tick or miss the last active tick. It makes writes, select toggles and feedback changes in the middle of a period. A design that loaded settings or sampled fb at once would produce runt pulses and bend a period in flight. It also changes the straps after reset. A design that kept sampling them would flip the polarity of the live output.

// File: rtl/pwm_drive_ctrl.sv
`timescale 1ns/1ps
module pwm_drive_ctrl #(
  parameter int NCH   = 2,
  parameter int DIVW  = 3,
  parameter int DUTYW = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NCH-1:0]              pol_strap,
  input  logic [NCH-1:0]              sel_pin,
  input  logic [NCH-1:0]              fb,
  input  logic                        wr_en,
  input  logic [$clog2(NCH):0]        wr_addr,
  input  logic [DIVW+DUTYW-1:0]       wr_data,
  output logic [NCH-1:0]              pwm_out
);
  localparam int CW   = $clog2(NCH);
  localparam int PREW = 2 ** DIVW;

  logic [NCH-1:0]       pol_v, sup_v, bnd_v;
  logic [NCH*DUTYW-1:0] duty_f, ph_f;
  logic [NCH*DIVW-1:0]  div_f;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DIVW-1:0]  div_q0, div_q1, act_div;
    logic [DUTYW-1:0] duty_q0, duty_q1, act_duty, ph;
    logic [PREW-1:0]  pre;
    logic [PREW:0]    span;
    logic             pol, sup, s1, s2, tick, bnd, wr_me;

    assign wr_me = wr_en && (wr_addr[CW:1] == CW'(c));
    assign span  = (PREW+1)'(2) << act_div;
    assign tick  = ({1'b0, pre} == span - 1'b1);
    assign bnd   = tick && (ph == '1);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        div_q0 <= '0; duty_q0 <= '0;
        div_q1 <= '0; duty_q1 <= '0;
      end else if (wr_me) begin
        if (wr_addr[0]) {div_q1, duty_q1} <= wr_data;
        else            {div_q0, duty_q0} <= wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pol      <= pol_strap[c];
        s1       <= 1'b0;
        s2       <= 1'b0;
        pre      <= '0;
        ph       <= '0;
        act_div  <= '0;
        act_duty <= '0;
        sup      <= 1'b0;
      end else begin
        s1  <= sel_pin[c];
        s2  <= s1;
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) ph <= ph + 1'b1;
        if (bnd) begin
          act_div  <= s2 ? div_q1  : div_q0;
          act_duty <= s2 ? duty_q1 : duty_q0;
          sup      <= fb[c];
        end
      end
    end

    assign pwm_out[c] = pol ^ (!sup && (ph < act_duty));

    assign pol_v[c] = pol;
    assign sup_v[c] = sup;
    assign bnd_v[c] = bnd;
    assign duty_f[c*DUTYW +: DUTYW] = act_duty;
    assign ph_f[c*DUTYW +: DUTYW]   = ph;
    assign div_f[c*DIVW +: DIVW]    = act_div;
  end
endmodule

// File: rtl/pwm_drive_chk.sv
`timescale 1ns/1ps
module pwm_drive_chk #(
  parameter int NCH   = 2,
  parameter int DIVW  = 3,
  parameter int DUTYW = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NCH-1:0]       pwm_out,
  input logic [NCH-1:0]       pol_v,
  input logic [NCH-1:0]       sup_v,
  input logic [NCH-1:0]       bnd_v,
  input logic [NCH*DUTYW-1:0] duty_f,
  input logic [NCH*DUTYW-1:0] ph_f,
  input logic [NCH*DIVW-1:0]  div_f
);
  for (genvar c = 0; c < NCH; c++) begin : g_a
    p_pol_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(pol_v[c]));
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bnd_v[c] |=> (ph_f[c*DUTYW +: DUTYW] == '0));
    p_duty_zero_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_f[c*DUTYW +: DUTYW] == '0) |-> (pwm_out[c] == pol_v[c]));
    p_mid_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd_v[c] |=> ($stable(duty_f[c*DUTYW +: DUTYW]) && $stable(div_f[c*DIVW +: DIVW])));
    p_fb_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sup_v[c] |-> (pwm_out[c] == pol_v[c]));
  end
endmodule

bind pwm_drive_ctrl pwm_drive_chk #(.NCH(NCH), .DIVW(DIVW), .DUTYW(DUTYW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .pol_v(pol_v), .sup_v(sup_v),
  .bnd_v(bnd_v), .duty_f(duty_f), .ph_f(ph_f), .div_f(div_f)
);

// File: tb/tb_pwm_drive_ctrl.sv
`timescale 1ns/1ps
module tb_pwm_drive_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pol_strap = 2'b10, sel_pin = 2'b00, fb = 2'b00;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'b00;
  logic [6:0] wr_data = 7'd0;
  logic [1:0] pwm_out;

  int nchk = 0, nfail = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  pwm_drive_ctrl dut (.clk(clk), .rst_n(rst_n), .pol_strap(pol_strap), .sel_pin(sel_pin),
                      .fb(fb), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
                      .pwm_out(pwm_out));

  int         m_cnt [2];
  logic [2:0] m_div [2];
  logic [3:0] m_duty [2];
  logic       m_sup [2], m_pol [2], m_s1 [2], m_s2 [2];
  logic [2:0] m_rdiv [2][2];
  logic [3:0] m_rduty [2][2];

  function automatic int period_len(input logic [2:0] d);
    return 16 << (d + 1);
  endfunction

  function automatic logic exp_out(input int c);
    logic on;
    on = !m_sup[c] && ((m_cnt[c] >> (m_div[c] + 1)) < int'(m_duty[c]));
    return m_pol[c] ^ on;
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (!rst_n) begin
        m_cnt[c] <= 0; m_div[c] <= 0; m_duty[c] <= 0; m_sup[c] <= 0;
        m_pol[c] <= pol_strap[c]; m_s1[c] <= 0; m_s2[c] <= 0;
        for (int s = 0; s < 2; s++) begin m_rdiv[c][s] <= 0; m_rduty[c][s] <= 0; end
      end else begin
        m_s1[c] <= sel_pin[c];
        m_s2[c] <= m_s1[c];
        if (m_cnt[c] == period_len(m_div[c]) - 1) begin
          m_cnt[c]  <= 0;
          m_div[c]  <= m_rdiv[c][m_s2[c]];
          m_duty[c] <= m_rduty[c][m_s2[c]];
          m_sup[c]  <= fb[c];
        end else m_cnt[c] <= m_cnt[c] + 1;
      end
    end
    if (rst_n && wr_en) begin
      m_rdiv[wr_addr[1]][wr_addr[0]]  <= wr_data[6:4];
      m_rduty[wr_addr[1]][wr_addr[0]] <= wr_data[3:0];
    end
  end

  task automatic check_outputs();
    for (int c = 0; c < 2; c++) begin
      logic e;
      e = exp_out(c);
      nchk++;
      if (pwm_out[c] !== e) begin
        nfail++;
        $display("FAIL %s ch%0d t=%0t: pwm_out=%b expected %b", cur_req, c, $time, pwm_out[c], e);
      end
    end
  endtask

  task automatic direct(input string req, input logic [1:0] got, input logic [1:0] want);
    nchk++;
    if (got !== want) begin
      nfail++;
      $display("FAIL %s direct t=%0t: got %b expected %b", req, $time, got, want);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); check_outputs(); end
  endtask

  task automatic wr(input logic [1:0] a, input logic [2:0] d, input logic [3:0] du);
    @(negedge clk); check_outputs();
    wr_en = 1'b1; wr_addr = a; wr_data = {d, du};
    @(negedge clk); check_outputs();
    wr_en = 1'b0;
  endtask

  task automatic rnd(input int n, input int wp, input int sp, input int fp);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); check_outputs();
      wr_en = (($urandom % 1000) < wp);
      if (wr_en) begin wr_addr = 2'($urandom); wr_data = 7'($urandom); end
      if (($urandom % sp) == 0) sel_pin = 2'($urandom);
      if (($urandom % fp) == 0) fb = 2'($urandom);
    end
    @(negedge clk); check_outputs();
    wr_en = 1'b0;
  endtask

  initial begin
    #(5ns * 150000);
    nfail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1badcafe));
    repeat (4) @(negedge clk);
    direct("R1", pwm_out, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    direct("R8", pwm_out, 2'b10);
    check_outputs();
    pol_strap = 2'b01;
    run(40);
    direct("R1", pwm_out, 2'b10);

    cur_req = "R3";
    wr(2'b00, 3'd0, 4'd5);
    wr(2'b10, 3'd1, 4'd15);
    run(700);
    wr(2'b00, 3'd0, 4'd0);
    run(200);

    cur_req = "R2";
    wr(2'b00, 3'd7, 4'd8);
    wr(2'b10, 3'd3, 4'd1);
    run(9000);

    cur_req = "R4";
    wr(2'b01, 3'd0, 4'd3);
    wr(2'b11, 3'd2, 4'd12);
    wr(2'b00, 3'd1, 4'd9);
    wr(2'b10, 3'd0, 4'd7);
    run(4200);
    sel_pin = 2'b11; run(400);
    sel_pin = 2'b01; run(400);
    sel_pin = 2'b10; @(negedge clk); check_outputs(); sel_pin = 2'b00; run(400);

    cur_req = "R6";
    fb = 2'b11; run(700);
    fb = 2'b01; run(700);
    rnd(2000, 0, 1000000, 1);
    fb = 2'b00;

    cur_req = "R5";
    rnd(12000, 20, 200, 50);

    cur_req = "R7";
    rnd(8000, 10, 97, 31);

    cur_req = "R8";
    wr(2'b01, 3'd0, 4'd15);
    wr(2'b00, 3'd0, 4'd15);
    sel_pin = 2'b00; fb = 2'b00;
    run(9000);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule